// File: doc/BRIEF.md
# UART FIFO DMA Ready-Signal Controller

This block owns the FIFO control register of one UART channel and turns the occupancy of its transmit and receive FIFOs into the two active-low DMA handshake lines, transmit-ready and receive-ready. It also produces a receive threshold interrupt request, a transmit space interrupt request, and one-cycle clear pulses for each FIFO. The FIFO storage, the serial shifters and the bus decode sit outside. They reach the block only as occupancy counts (0 to 16) and a register write strobe.

Two handshake schemes are supported. In the single-character scheme, transmit-ready asks for data only when the transmit path is completely empty, and receive-ready flags any waiting character. This scheme also covers operation with the FIFOs disabled, where the counts are 0 or 1. In the block scheme, transmit-ready stays active while any transmit slot is free, and receive-ready stays active while the receive fill is at or above a programmed threshold. The receive FIFO keeps accepting characters past that threshold until it is full. Receive-ready is only driven when the multifunction pin is configured to carry it.

Top module: `uart_dma_ready`

## Requirements
- R1: During and right after reset, txRdyN and rxRdyN are 1, rxTrigIrq, txSpaceIrq, rxClear and txClear are 0, and fcrView is 0x00.
- R2: A write (fcrWrEn=1) loads the register at that clock edge. From the next cycle on, fcrView shows the written bits 7:6, 3 and 0. Bits 5:4 and 2:1 of fcrView always read 0.
- R3: A write with bit 1 set gives rxClear=1 for exactly the cycle after the write edge. A write with bit 2 set does the same on txClear. With no such write, both are 0.
- R4: In the single-character scheme (bit 0 = 0, or bit 3 = 0), txRdyN is 0 exactly when txCount is 0.
- R5: In the single-character scheme, with the pin in receive-ready mode, rxRdyN is 0 exactly when rxCount is at least 1.
- R6: In the block scheme (bit 0 = 1 and bit 3 = 1), txRdyN is 0 exactly when txCount is below 16. In every scheme, txSpaceIrq equals the inverse of txRdyN.
- R7: In the block scheme, with the pin in receive-ready mode, rxRdyN is 0 exactly when rxCount is at or above the threshold selected by bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R8: With bit 0 = 0, bit 3 has no effect, and the single-character rules apply.
- R9: With pinModeRxRdy = 0, rxRdyN is held at 1 whatever the receive count.
- R10: rxTrigIrq is 1 when the FIFOs are enabled (bit 0 = 1) and rxCount is at or above the selected threshold, whatever bit 3 holds. It is also 1 when the FIFOs are disabled and rxCount is at least 1.
- R11: All outputs are registered. Each output in a cycle reflects the inputs and register contents present just before the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fcrWrEn | input | 1 | Write strobe for the FIFO control register |
| fcrWrData | input | 8 | Data written to the FIFO control register |
| txCount | input | CNT_W (5) | Transmit FIFO plus holding register occupancy |
| rxCount | input | CNT_W (5) | Receive FIFO occupancy |
| pinModeRxRdy | input | 1 | Multifunction pin set to carry receive-ready |
| txRdyN | output | 1 | Active-low transmit DMA ready |
| rxRdyN | output | 1 | Active-low receive DMA ready |
| rxTrigIrq | output | 1 | Receive threshold interrupt request |
| txSpaceIrq | output | 1 | Transmit space interrupt request |
| rxClear | output | 1 | One-cycle receive FIFO clear pulse |
| txClear | output | 1 | One-cycle transmit FIFO clear pulse |
| fcrView | output | 8 | Current register image with unused and strobe bits at 0 |

## Verification
Every result is due one clock edge after the stimulus that causes it. A register write shows on fcrView and on the clear pulses in the cycle after the write edge. A count change or pin-mode change shows on the ready lines and interrupts in the cycle after the edge that samples it. The reference model in the bench captures inputs at each rising edge and forms its expectation for the following cycle from them. It compares all outputs at the falling edge, when they are settled. The sweeps move txCount and rxCount across 0 to 16 under each scheme and threshold, so every boundary is sampled on both sides.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  // Configuration and strobes passed from the register control to the datapath.
  typedef struct packed {
    logic       fifoEn;    // FIFOs enabled
    logic       dmaMode1;  // block handshake scheme selected
    logic [1:0] trigSel;   // receive threshold code
    logic       rxClr;     // one-cycle receive clear
    logic       txClr;     // one-cycle transmit clear
  } fcrCtrl_t;

endpackage

// File: rtl/uart_dma_fcr_ctrl.sv
module uart_dma_fcr_ctrl
  import uart_dma_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fcrWrEn,
  input  logic [REG_W-1:0] fcrWrData,
  output fcrCtrl_t         ctrl,
  output logic [REG_W-1:0] fcrView
);

  logic       fifoEnQ;
  logic       dmaQ;
  logic [1:0] trigQ;
  logic       rxClrQ;
  logic       txClrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ <= 1'b0;
      dmaQ    <= 1'b0;
      trigQ   <= 2'b00;
      rxClrQ  <= 1'b0;
      txClrQ  <= 1'b0;
    end else begin
      rxClrQ <= fcrWrEn & fcrWrData[1];
      txClrQ <= fcrWrEn & fcrWrData[2];
      if (fcrWrEn) begin
        fifoEnQ <= fcrWrData[0];
        dmaQ    <= fcrWrData[3];
        trigQ   <= fcrWrData[7:6];
      end
    end
  end

  always_comb begin
    ctrl.fifoEn   = fifoEnQ;
    ctrl.dmaMode1 = dmaQ;
    ctrl.trigSel  = trigQ;
    ctrl.rxClr    = rxClrQ;
    ctrl.txClr    = txClrQ;
    fcrView        = '0;
    fcrView[0]     = fifoEnQ;
    fcrView[3]     = dmaQ;
    fcrView[7:6]   = trigQ;
  end

  // R3: a clear pulse only follows a write carrying the matching bit
  assert_rxclr_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxClrQ |-> $past(fcrWrEn && fcrWrData[1]));
  assert_txclr_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    txClrQ |-> $past(fcrWrEn && fcrWrData[2]));

  // R2: a write is visible one cycle later
  assert_fcr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    fcrWrEn |=> (fcrView[7:6] == $past(fcrWrData[7:6]) &&
                 fcrView[3] == $past(fcrWrData[3]) &&
                 fcrView[0] == $past(fcrWrData[0])));

endmodule

// File: rtl/uart_dma_ready_dp.sv
module uart_dma_ready_dp
  import uart_dma_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int CNT_W   = 5,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcrCtrl_t         ctrl,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             pinModeRxRdy,
  output logic             txRdyN,
  output logic             rxRdyN,
  output logic             rxTrigIrq,
  output logic             txSpaceIrq
);

  localparam int                NUM_TRIG = 4;
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

  logic [NUM_TRIG-1:0] geTrig;
  logic                blockMode;
  logic                atTrig;
  logic                txWant;
  logic                rxWant;
  logic                rxIrqD;

  // One comparator per threshold choice; the selector picks one.
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    localparam int LV = (i == 0) ? TRIG_L0 :
                        (i == 1) ? TRIG_L1 :
                        (i == 2) ? TRIG_L2 : TRIG_L3;
    assign geTrig[i] = (rxCount >= CNT_W'(LV));
  end

  always_comb begin
    blockMode = ctrl.fifoEn & ctrl.dmaMode1;
    atTrig    = geTrig[ctrl.trigSel];
    txWant    = blockMode ? (txCount < DEPTH_C) : (txCount == '0);
    rxWant    = blockMode ? atTrig : (rxCount != '0);
    rxIrqD    = ctrl.fifoEn ? atTrig : (rxCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRdyN     <= 1'b1;
      rxRdyN     <= 1'b1;
      rxTrigIrq  <= 1'b0;
      txSpaceIrq <= 1'b0;
    end else begin
      txRdyN     <= ~txWant;
      rxRdyN     <= ~(rxWant & pinModeRxRdy);
      rxTrigIrq  <= rxIrqD;
      txSpaceIrq <= txWant;
    end
  end

  // R6: block scheme keeps transmit-ready active while a slot is free
  assert_tx_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fifoEn && ctrl.dmaMode1 && txCount < DEPTH_C) |=> !txRdyN);
  // R4: single-character scheme releases transmit-ready once data is present
  assert_tx_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(ctrl.fifoEn && ctrl.dmaMode1) && txCount != '0) |=> txRdyN);
  // R5: single-character scheme flags any waiting character
  assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!(ctrl.fifoEn && ctrl.dmaMode1) && pinModeRxRdy && rxCount != '0) |=> !rxRdyN);
  // R9: receive-ready held inactive when the pin carries another function
  assert_rx_pin_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pinModeRxRdy |=> rxRdyN);
  // R7: full receive FIFO is at or above every threshold
  assert_rx_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fifoEn && ctrl.dmaMode1 && pinModeRxRdy && rxCount == DEPTH_C) |=> !rxRdyN);

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_pkg::*;
#(
  parameter int  DEPTH   = 16,
  parameter int  TRIG_L0 = 1,
  parameter int  TRIG_L1 = 4,
  parameter int  TRIG_L2 = 8,
  parameter int  TRIG_L3 = 14,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fcrWrEn,
  input  logic [7:0]       fcrWrData,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             pinModeRxRdy,
  output logic             txRdyN,
  output logic             rxRdyN,
  output logic             rxTrigIrq,
  output logic             txSpaceIrq,
  output logic             rxClear,
  output logic             txClear,
  output logic [7:0]       fcrView
);

  fcrCtrl_t ctrl;

  uart_dma_fcr_ctrl #(.REG_W(8)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fcrWrEn   (fcrWrEn),
    .fcrWrData (fcrWrData),
    .ctrl      (ctrl),
    .fcrView   (fcrView)
  );

  uart_dma_ready_dp #(
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W),
    .TRIG_L0 (TRIG_L0),
    .TRIG_L1 (TRIG_L1),
    .TRIG_L2 (TRIG_L2),
    .TRIG_L3 (TRIG_L3)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .pinModeRxRdy (pinModeRxRdy),
    .txRdyN       (txRdyN),
    .rxRdyN       (rxRdyN),
    .rxTrigIrq    (rxTrigIrq),
    .txSpaceIrq   (txSpaceIrq)
  );

  assign rxClear = ctrl.rxClr;
  assign txClear = ctrl.txClr;

endmodule

// File: tb/test_uart_dma_ready.sv
`timescale 1ns/1ps
module test_uart_dma_ready;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fcrWrEn = 1'b0;
  logic [7:0] fcrWrData = 8'h00;
  logic [4:0] txCount = '0;
  logic [4:0] rxCount = '0;
  logic       pinModeRxRdy = 1'b1;
  logic       txRdyN, rxRdyN, rxTrigIrq, txSpaceIrq, rxClear, txClear;
  logic [7:0] fcrView;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  uart_dma_ready i_uart_dma_ready (
    .clk(clk), .rstN(rstN), .fcrWrEn(fcrWrEn), .fcrWrData(fcrWrData),
    .txCount(txCount), .rxCount(rxCount), .pinModeRxRdy(pinModeRxRdy),
    .txRdyN(txRdyN), .rxRdyN(rxRdyN), .rxTrigIrq(rxTrigIrq),
    .txSpaceIrq(txSpaceIrq), .rxClear(rxClear), .txClear(txClear),
    .fcrView(fcrView)
  );

  // Behavioural reference: model register plus expected outputs for next cycle
  bit    mFifo, mDma;
  int    mTrig;
  bit    eTxN, eRxN, eRxIrq, eTxIrq, eRxClr, eTxClr;
  int    eView;
  string tagTx, tagRx, tagIrq;

  function automatic int trigOf(int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFifo <= 0; mDma <= 0; mTrig <= 0;
      eTxN <= 1; eRxN <= 1; eRxIrq <= 0; eTxIrq <= 0;
      eRxClr <= 0; eTxClr <= 0; eView <= 0;
      tagTx <= "R1"; tagRx <= "R1"; tagIrq <= "R1";
    end else begin
      bit blk;
      bit txOk;
      int tv;
      blk  = mFifo && mDma;
      tv   = trigOf(mTrig);
      txOk = blk ? (int'(txCount) < 16) : (txCount == 0);
      eTxN   <= !txOk;
      eTxIrq <= txOk;
      eRxN   <= pinModeRxRdy ? !(blk ? (int'(rxCount) >= tv) : (rxCount >= 1)) : 1'b1;
      eRxIrq <= mFifo ? (int'(rxCount) >= tv) : (rxCount >= 1);
      eRxClr <= fcrWrEn && fcrWrData[1];
      eTxClr <= fcrWrEn && fcrWrData[2];
      tagTx  <= blk ? "R6/R11" : (!mFifo && mDma) ? "R8/R4" : "R4/R11";
      tagRx  <= !pinModeRxRdy ? "R9" : blk ? "R7/R11" : (!mFifo && mDma) ? "R8/R5" : "R5/R11";
      tagIrq <= "R10/R11";
      if (fcrWrEn) begin
        mFifo <= fcrWrData[0];
        mDma  <= fcrWrData[3];
        mTrig <= int'(fcrWrData[7:6]);
        eView <= int'({fcrWrData[7:6], 2'b00, fcrWrData[3], 3'b000}) | int'(fcrWrData[0]);
      end
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tagTx, int'(txRdyN), int'(eTxN), "txRdyN");
      check(tagRx, int'(rxRdyN), int'(eRxN), "rxRdyN");
      check(tagIrq, int'(rxTrigIrq), int'(eRxIrq), "rxTrigIrq");
      check(rstN ? "R6" : "R1", int'(txSpaceIrq), int'(eTxIrq), "txSpaceIrq");
      check(rstN ? "R3" : "R1", int'(rxClear), int'(eRxClr), "rxClear");
      check(rstN ? "R3" : "R1", int'(txClear), int'(eTxClr), "txClear");
      check(rstN ? "R2" : "R1", int'(fcrView), eView, "fcrView");
    end
  end

  task automatic wrFcr(input logic [7:0] d);
    @(negedge clk);
    fcrWrEn = 1'b1; fcrWrData = d;
    @(negedge clk);
    fcrWrEn = 1'b0; fcrWrData = 8'h00;
  endtask

  task automatic sweep(input int maxTx, input int maxRx);
    for (int t = 0; t <= maxTx; t++) begin
      @(negedge clk); txCount = 5'(t);
    end
    for (int r = 0; r <= maxRx; r++) begin
      @(negedge clk); rxCount = 5'(r);
    end
    @(negedge clk); txCount = '0; rxCount = '0;
  endtask

  task automatic finishRun;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;                 // R1 checked in the reset cycles
    sweep(1, 1);                 // FIFOs disabled, single-character: R4 R5
    wrFcr(8'h08);                // bit 3 without bit 0: R8
    sweep(2, 2);
    wrFcr(8'h01);                // FIFOs on, single-character scheme
    sweep(16, 16);
    for (int c = 0; c < 4; c++) begin  // block scheme, each threshold: R6 R7 R10
      wrFcr(8'(c << 6) | 8'h09);
      sweep(16, 16);
    end
    wrFcr(8'hC1);                // R10 threshold irq without block scheme
    sweep(0, 16);
    wrFcr(8'h4F);                // clear strobes with block scheme: R3
    wrFcr(8'h0B);                // receive clear only
    wrFcr(8'h0D);                // transmit clear only
    @(negedge clk); pinModeRxRdy = 1'b0;   // R9
    sweep(3, 16);
    pinModeRxRdy = 1'b1;
    wrFcr(8'hFF);                // R2: unused and strobe bits read 0
    @(negedge clk); txCount = 5'd16; rxCount = 5'd16;
    repeat (3) @(negedge clk);
    wrFcr(8'h00);                // back to single-character, full counts
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

endmodule